// File: doc/BRIEF.md
# Five-Port Binary Byte Listener

This block sits behind a byte-wide bus receiver. While its raw-data mode is active it treats every byte it receives as port data. The first byte of a group lands in the highest-numbered output port, and each following byte goes to the next lower port. A group is complete after five bytes, or earlier when a byte arrives flagged as the end of the transfer (EOI). Either way, the block then raises a data strobe. The strobe lasts a fixed time, which the block converts to clock cycles from the clock frequency.

A new byte offered while the strobe is high is stalled through the ready signal until the strobe ends. A clear request received in raw-data mode does not reset the unit. Instead it drops the block back into command mode, returns the byte position to the first port and leaves the port contents alone. It also suppresses the clear pulse that the same request produces in command mode. Command mode is entered from reset. Raw-data mode is entered with a one-cycle mode-set pulse.

Top module: `quint_port_listener`

## Requirements
- R1: After a clock edge with `rst_n` low, `port_bus` is all zeros, and `strobe`, `raw_mode` and `clr_pulse` are low.
- R2: A cycle with `mode_set` high and `clear_req` low makes `raw_mode` high from the next edge on, and the next accepted byte goes to port 5.
- R3: In raw-data mode, byte k of a group (k = 0..4) is written to port 5-k on the edge that accepts it. Port n occupies bits [8n-1:8n-8] of `port_bus`, so port 5 is bits [39:32] and port 1 is bits [7:0].
- R4: Accepting the fifth byte of a group raises `strobe` from that same edge, and the following byte goes to port 5.
- R5: An accepted byte with `rx_eoi` high ends the group early and raises `strobe` the same way. Ports that the short group did not reach keep their previous values, and the next byte goes to port 5.
- R6: `strobe` stays high for exactly STROBE_CYCLES = CLK_MHZ*STROBE_NS/1000 consecutive cycles per group.
- R7: `rx_ready` is low whenever `strobe` is high. An offered byte is held and is accepted on the first edge after the strobe has fallen.
- R8: In raw-data mode no byte value has a special meaning. A byte such as 0x55 (ASCII 'U') is stored like any other.
- R9: `clear_req` in raw-data mode clears `raw_mode` on the next edge, keeps `clr_pulse` low, leaves `port_bus` unchanged and returns the position to port 5. A byte offered in that cycle is not stored.
- R10: `clear_req` in command mode raises `clr_pulse` for exactly one cycle, starting at the next edge.
- R11: In command mode, offered bytes change neither `port_bus` nor `strobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_set | input | 1 | One-cycle pulse that enters raw-data mode |
| clear_req | input | 1 | Device clear request from the bus |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is present |
| rx_eoi | input | 1 | Received byte ends the transfer |
| rx_ready | output | 1 | Block can take a byte this cycle |
| port_bus | output | 40 | Port registers 5..1, port 5 in the top byte |
| strobe | output | 1 | Data strobe, fixed width |
| raw_mode | output | 1 | High while raw-data mode is active |
| clr_pulse | output | 1 | One-cycle clear pulse for command mode |

## Verification
The assertions check on every cycle that the strobe has its exact width and blocks `rx_ready`, that it only rises after an accepted byte, that clears behave as the mode requires, and that command mode never touches the ports. Only the bench scenarios can show the placement of each byte into its port, the early end of a group on EOI with the untouched ports kept, and the position returning to port 5 after a strobe or a clear. The same holds for a byte being held across a strobe and then landing in the right place.

// File: rtl/qpl_pkg.sv
// Shared definitions for the five-port listener.
// Assumes: clock given in MHz, strobe width in nanoseconds.
package qpl_pkg;

    typedef enum logic {
        MODE_CMD = 1'b0,
        MODE_RAW = 1'b1
    } qpl_mode_e;

    // Converts a time in ns to a cycle count, never less than one
    function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                                 input int unsigned t_ns);
        int unsigned c;
        c = (clk_mhz * t_ns) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/qpl_mode_ctrl.sv
// Mode flag and clear pulse.
// Holds command vs raw-data mode. In raw-data mode a clear request only
// leaves the mode; in command mode it yields a one-cycle clear pulse.
// Assumes: clear_req has priority over mode_set.
module qpl_mode_ctrl
    import qpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_set,
    input  logic clear_req,
    output logic raw_mode,
    output logic clr_pulse
);

    qpl_mode_e mode_q;

    // Mode register: clear wins over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CMD;
        end else if (clear_req) begin
            mode_q <= MODE_CMD;
        end else if (mode_set) begin
            mode_q <= MODE_RAW;
        end
    end

    // Clear pulse only for a clear taken in command mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= clear_req && (mode_q == MODE_CMD);
        end
    end

    assign raw_mode = (mode_q == MODE_RAW);

endmodule

// File: rtl/qpl_slot_ctrl.sv
// Byte position sequencer.
// Accepts a byte when valid, ready and in raw-data mode with no clear,
// reports which slot it fills and whether it closes the group.
// Assumes: slot 0 maps to the highest port.
module qpl_slot_ctrl #(
    parameter int NPORTS = 5,
    localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_eoi,
    input  logic              rx_ready,
    input  logic              raw_mode,
    input  logic              clear_req,
    input  logic              mode_set,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              group_done
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NPORTS - 1);

    logic [SLOT_W-1:0] slot_q;

    // Accept decode and group end detection
    always_comb begin
        wr_en      = rx_valid && rx_ready && raw_mode && !clear_req;
        wr_slot    = slot_q;
        group_done = wr_en && (rx_eoi || (slot_q == LAST_SLOT));
    end

    // Slot counter: back to the first port after a group, clear or mode entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (clear_req || mode_set || group_done) begin
            slot_q <= '0;
        end else if (wr_en) begin
            slot_q <= slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/qpl_port_bank.sv
// Output port registers.
// One register per port; slot k writes port NPORTS-k (1-based), which sits
// at register index NPORTS-1-k of the flat bus.
module qpl_port_bank #(
    parameter int NPORTS = 5,
    parameter int WIDTH  = 8,
    localparam int SLOT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [WIDTH-1:0]        wr_data,
    output logic [NPORTS*WIDTH-1:0] port_bus
);

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(NPORTS - 1 - i);
        logic [WIDTH-1:0] reg_q;

        // Port register: loads when its slot is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else if (wr_en && (wr_slot == MY_SLOT)) begin
                reg_q <= wr_data;
            end
        end

        assign port_bus[i*WIDTH +: WIDTH] = reg_q;
    end

endmodule

// File: rtl/qpl_strobe_timer.sv
// Fixed-width strobe generator.
// A start pulse makes strobe high for exactly CYCLES clock cycles,
// beginning at the edge that samples start.
// Assumes: start does not arrive while strobe is high.
module qpl_strobe_timer #(
    parameter int CYCLES = 15,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic strobe
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter holding the remaining high cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !strobe) begin
            strobe <= 1'b1;
            cnt_q  <= LOAD;
        end else if (strobe) begin
            if (cnt_q == '0) begin
                strobe <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/quint_port_listener.sv
// Five-port binary byte listener, top level.
// Spreads received bytes over the port registers highest port first,
// strobes after a full or EOI-terminated group, and leaves raw-data mode
// on a clear request without a clear pulse.
// Assumes: the bus handshake, addressing and command parsing live outside.
module quint_port_listener
    import qpl_pkg::*;
#(
    parameter int NPORTS    = 5,
    parameter int WIDTH     = 8,
    parameter int CLK_MHZ   = 250,
    parameter int STROBE_NS = 15000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_set,
    input  logic                    clear_req,
    input  logic [WIDTH-1:0]        rx_data,
    input  logic                    rx_valid,
    input  logic                    rx_eoi,
    output logic                    rx_ready,
    output logic [NPORTS*WIDTH-1:0] port_bus,
    output logic                    strobe,
    output logic                    raw_mode,
    output logic                    clr_pulse
);

    localparam int STROBE_CYCLES = int'(ns_to_cycles(CLK_MHZ, STROBE_NS));
    localparam int SLOT_W        = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic              group_done;

    // Bytes are stalled for the whole strobe
    assign rx_ready = !strobe;

    qpl_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_set  (mode_set),
        .clear_req (clear_req),
        .raw_mode  (raw_mode),
        .clr_pulse (clr_pulse)
    );

    qpl_slot_ctrl #(.NPORTS(NPORTS)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_eoi     (rx_eoi),
        .rx_ready   (rx_ready),
        .raw_mode   (raw_mode),
        .clear_req  (clear_req),
        .mode_set   (mode_set),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .group_done (group_done)
    );

    qpl_port_bank #(.NPORTS(NPORTS), .WIDTH(WIDTH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (rx_data),
        .port_bus (port_bus)
    );

    qpl_strobe_timer #(.CYCLES(STROBE_CYCLES)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (group_done),
        .strobe (strobe)
    );

endmodule

// File: rtl/qpl_checker.sv
// Property checker for the five-port listener, bound to the top.
// Uses a counter to measure the strobe width rather than a long delay.
module qpl_checker #(
    parameter int NPORTS        = 5,
    parameter int WIDTH         = 8,
    parameter int STROBE_CYCLES = 15,
    localparam int HC_W = $clog2(STROBE_CYCLES + 2) + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rx_valid,
    input logic                    rx_ready,
    input logic                    raw_mode,
    input logic                    clear_req,
    input logic                    clr_pulse,
    input logic                    strobe,
    input logic [NPORTS*WIDTH-1:0] port_bus
);

    logic [HC_W-1:0] hi_cnt;

    // Counts consecutive high strobe cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (strobe) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_strobe_not_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (hi_cnt < HC_W'(STROBE_CYCLES)));

    assert_strobe_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && hi_cnt != '0) |-> (hi_cnt == HC_W'(STROBE_CYCLES)));

    assert_stall_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !rx_ready);

    // R4 and R5: a strobe only starts from an accepted byte
    assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(rx_valid && rx_ready && raw_mode && !clear_req));

    assert_raw_clear_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && raw_mode) |=> (!raw_mode && !clr_pulse));

    assert_raw_clear_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && raw_mode) |=> $stable(port_bus));

    assert_cmd_clear_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !raw_mode) |=> clr_pulse);

    assert_cmd_ports_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_mode |=> $stable(port_bus));

endmodule

bind quint_port_listener qpl_checker #(
    .NPORTS        (NPORTS),
    .WIDTH         (WIDTH),
    .STROBE_CYCLES (STROBE_CYCLES)
) u_qpl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .raw_mode  (raw_mode),
    .clear_req (clear_req),
    .clr_pulse (clr_pulse),
    .strobe    (strobe),
    .port_bus  (port_bus)
);

// File: tb/test_quint_port_listener.sv
`timescale 1ns/1ps
// Bench for the five-port listener: a vector table of bytes and expected
// port contents, then directed tests for reset, clears and stalls.
module test_quint_port_listener;

    localparam int SC = 15;   // 250 MHz * 60 ns / 1000

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_set = 1'b0;
    logic        clear_req = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_eoi = 1'b0;
    logic        rx_ready;
    logic [39:0] port_bus;
    logic        strobe;
    logic        raw_mode;
    logic        clr_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    quint_port_listener #(.CLK_MHZ(250), .STROBE_NS(60)) i_quint_port_listener (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .clear_req(clear_req),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_eoi(rx_eoi),
        .rx_ready(rx_ready), .port_bus(port_bus), .strobe(strobe),
        .raw_mode(raw_mode), .clr_pulse(clr_pulse)
    );

    // {data, eoi, strobe expected, port_bus expected}
    localparam int NV = 13;
    localparam logic [49:0] VEC [NV] = '{
        {8'h11, 1'b0, 1'b0, 40'h11_00_00_00_00},
        {8'h22, 1'b0, 1'b0, 40'h11_22_00_00_00},
        {8'h33, 1'b0, 1'b0, 40'h11_22_33_00_00},
        {8'h44, 1'b0, 1'b0, 40'h11_22_33_44_00},
        {8'h55, 1'b0, 1'b1, 40'h11_22_33_44_55},
        {8'hA1, 1'b0, 1'b0, 40'hA1_22_33_44_55},
        {8'hB2, 1'b1, 1'b1, 40'hA1_B2_33_44_55},
        {8'hC3, 1'b1, 1'b1, 40'hC3_B2_33_44_55},
        {8'h01, 1'b0, 1'b0, 40'h01_B2_33_44_55},
        {8'h02, 1'b0, 1'b0, 40'h01_02_33_44_55},
        {8'h03, 1'b0, 1'b0, 40'h01_02_03_44_55},
        {8'h04, 1'b0, 1'b0, 40'h01_02_03_04_55},
        {8'h05, 1'b0, 1'b1, 40'h01_02_03_04_05}
    };

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offers one byte at a negedge; returns at the negedge after acceptance
    task automatic send_byte(input logic [7:0] d, input logic e, output int waited);
        waited = 0;
        @(negedge clk);
        rx_data = d; rx_eoi = e; rx_valid = 1'b1;
        while (!rx_ready) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eoi = 1'b0;
    endtask

    // Counts strobe high cycles from the current negedge
    task automatic measure_strobe(output int width, output int ready_bad);
        width = 0; ready_bad = 0;
        while (strobe && width < 4 * SC) begin
            if (rx_ready) ready_bad++;
            width++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, rb, wt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {port_bus[39:3], strobe, raw_mode, clr_pulse}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: bytes in command mode are ignored
        send_byte(8'h99, 1'b1, wt);
        check("R11", {port_bus[39:1], strobe}, 40'h0);
        repeat (2) @(negedge clk);
        check("R11 later", {port_bus[39:1], strobe}, 40'h0);

        // R10: clear in command mode gives a one-cycle pulse
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        check("R10 pulse", {39'h0, clr_pulse}, 40'h1);
        @(negedge clk);
        check("R10 single", {39'h0, clr_pulse}, 40'h0);

        // R2: enter raw-data mode
        mode_set = 1'b1;
        @(negedge clk);
        mode_set = 1'b0;
        check("R2", {39'h0, raw_mode}, 40'h1);

        // R3 R4 R5 R6 R8: vector table
        for (int i = 0; i < NV; i++) begin
            send_byte(VEC[i][49:42], VEC[i][41], wt);
            check($sformatf("R3 vec%0d", i), port_bus, VEC[i][39:0]);
            check($sformatf("R4/R5 strobe vec%0d", i), {39'h0, strobe}, {39'h0, VEC[i][40]});
            if (VEC[i][40]) begin
                measure_strobe(w, rb);
                check("R6 width", 40'(w), 40'(SC));
                check("R7 ready low", 40'(rb), 40'h0);
            end
        end
        // R8 is covered by vec4 storing 0x55

        // R7: byte offered right after a group end is held
        send_byte(8'h77, 1'b1, wt);
        check("R7 strobe", {39'h0, strobe}, 40'h1);
        send_byte(8'h88, 1'b0, wt);
        check("R7 held cycles", 40'(wt), 40'(SC - 1));
        check("R7 landed port5", port_bus, 40'h88_02_03_04_05);
        check("R7 no strobe", {39'h0, strobe}, 40'h0);

        // R9: clear in raw-data mode mid-group
        send_byte(8'h99, 1'b0, wt);
        check("R9 setup", port_bus, 40'h88_99_03_04_05);
        @(negedge clk);
        clear_req = 1'b1; rx_valid = 1'b1; rx_data = 8'hEE;
        @(negedge clk);
        clear_req = 1'b0; rx_valid = 1'b0;
        check("R9 mode", {38'h0, raw_mode, clr_pulse}, 40'h0);
        check("R9 ports", port_bus, 40'h88_99_03_04_05);
        @(negedge clk);
        check("R9 no pulse", {39'h0, clr_pulse}, 40'h0);
        mode_set = 1'b1;
        @(negedge clk);
        mode_set = 1'b0;
        send_byte(8'h5A, 1'b1, wt);
        check("R9 position reset", port_bus, 40'h5A_99_03_04_05);
        measure_strobe(w, rb);
        check("R6 width eoi1", 40'(w), 40'(SC));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule